// File: doc/BRIEF.md
# I2C Controller Register and FIFO Front-End

This block sits between a processor's register bus and an I2C byte engine. Firmware writes a 32-bit configuration word. That word selects the data-movement mode and the bus speed class, and it requests FIFO clears and turns the controller on or off. Firmware reads a live 32-bit status word that reports receive progress. Bytes that firmware writes through the egress port wait in a 16-entry transmit FIFO until the engine takes them. Bytes that the engine delivers wait in a 16-entry receive FIFO until firmware reads them through the ingress port.

The block also produces the SCL clock waveform. The period is a fixed number of system clocks. The high phase is half of that period in the standard-speed mode, or two fifths of it otherwise.

Turning the enable bit off does not cut a byte in half. The run signal toward the engine stays high until the engine reports that it is idle. At that point all transfer state is reset, and any unread receive data is thrown away.

Top module: `i2c_regfront`

## Requirements
- R1: After reset, the configuration reads 0x00000004, the status reads 0, SCL is high, run is low, tx_valid is low and the ingress data reads 0.
- R2: A configuration write stores bits 0, 2, 29, 30 and 31, and every other bit reads back as 0. While bit 0 (DMA mode) is 1, status bits 1 and 2 read as 0.
- R3: While running with a divider of DIV clocks, SCL is high for DIV/2 clocks and low for the rest when bit 2 is 1. It is high for DIV*2/5 clocks and low for the rest when bit 2 is 0. SCL is high while not running.
- R4: Each byte that the receive FIFO accepts from the engine raises status bit 0 for exactly one cycle, in the cycle after the byte is offered.
- R5: Status bit 1 is 1 when the receive FIFO holds at least one byte. Status bit 2 is 1 when it holds 8 or more bytes. Both bits follow an ingress read in the next cycle.
- R6: An ingress read returns the oldest received byte one cycle later, in arrival order. A read of an empty receive FIFO returns 0 and changes nothing.
- R7: While bit 29 is 1, the receive FIFO is emptied and status bit 1 reads 0.
- R8: While bit 30 is 1 and bit 31 is 0, the transmit FIFO is emptied and status bit 3 reads 1. While bit 31 is 1, bit 30 has no effect.
- R9: When bit 31 is cleared while eng_busy is 1, run stays high. In the cycle after eng_busy falls, run goes low, the receive FIFO empties and the ingress data reads 0.
- R10: While running, tx_valid is high whenever the transmit FIFO is not empty, and tx_data presents the egress bytes in write order. Each cycle with tx_take high removes one byte.
- R11: A byte offered to a full FIFO (16 entries) is dropped, and the contents stay unchanged.
- R12: Receive bytes from the engine are ignored while run is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_o | output | 32 | Configuration register value |
| status_o | output | 32 | Live status word |
| in_rd_i | input | 1 | Ingress data read strobe |
| in_data_o | output | 8 | Ingress data register |
| eg_wr_i | input | 1 | Egress data write strobe |
| eg_data_i | input | 8 | Egress data byte |
| tx_valid_o | output | 1 | A transmit byte is offered to the engine |
| tx_data_o | output | 8 | Offered transmit byte |
| tx_take_i | input | 1 | Engine takes the offered byte |
| rx_valid_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| eng_busy_i | input | 1 | Engine is in the middle of a byte |
| run_o | output | 1 | Controller running, toward the engine |
| scl_o | output | 1 | Generated SCL waveform |

## Verification
Corrupted FIFO pointers or counts show up at the ports as bytes returned out of order, missing or duplicated. A wrong fill count shows up in the data-available and half-full flags. Both kinds of fault appear on the very next ingress read or transmit hand-off, because the scoreboard compares every byte against the order in which it was written. A stuck drain state shows up as run staying high, or falling early, around the eng_busy release. The bench checks this in the single cycle after release. A wrong divider phase changes the measured SCL high and low lengths within one period.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  // configuration bit positions
  localparam int CFG_DMA   = 0;
  localparam int CFG_STD   = 2;
  localparam int CFG_RXCLR = 29;
  localparam int CFG_TXCLR = 30;
  localparam int CFG_EN    = 31;
  localparam logic [31:0] CFG_RESET = 32'h0000_0004;
  localparam logic [31:0] CFG_MASK  = 32'hE000_0005;
  // status bit positions
  localparam int ST_RXDONE = 0;
  localparam int ST_RXDATA = 1;
  localparam int ST_RXHALF = 2;
  localparam int ST_TXDONE = 3;
endpackage

// File: rtl/i2c_rf_fifo.sv
module i2c_rf_fifo #(
  parameter int W = 8,
  parameter int D = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   push,
  input  logic [W-1:0]           wdata,
  input  logic                   pop,
  output logic [W-1:0]           rdata,
  output logic [$clog2(D+1)-1:0] count,
  output logic                   full,
  output logic                   empty
);
  localparam int AW = $clog2(D);
  localparam int CW = $clog2(D+1);

  logic [W-1:0]  mem [D];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(D));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);
  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !flush) |=> empty);
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/i2c_rf_sclgen.sv
module i2c_rf_sclgen #(
  parameter int unsigned DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic std_mode,
  output logic scl
);
  localparam logic [15:0] HI_STD  = 16'(DIV / 2);
  localparam logic [15:0] HI_FAST = 16'((DIV * 2) / 5);
  localparam logic [15:0] LAST    = 16'(DIV - 1);

  logic [15:0] cnt;
  logic [15:0] hi;

  assign hi = std_mode ? HI_STD : HI_FAST;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      scl <= 1'b1;
    end else begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      scl <= (cnt < hi);
    end
  end

  // R3
  scl_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> scl);
endmodule

// File: rtl/i2c_regfront.sv
module i2c_regfront
  import i2c_rf_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          BYTE_W  = 8,
  parameter int unsigned SCL_DIV = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_o,
  output logic [31:0]       status_o,
  input  logic              in_rd_i,
  output logic [BYTE_W-1:0] in_data_o,
  input  logic              eg_wr_i,
  input  logic [BYTE_W-1:0] eg_data_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_take_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              eng_busy_i,
  output logic              run_o,
  output logic              scl_o
);
  localparam int CW   = $clog2(DEPTH+1);
  localparam int HALF = DEPTH / 2;

  logic [31:0]       cfg_q;
  logic              run_q, rx_done_q, tx_done_q;
  logic [BYTE_W-1:0] in_q;
  logic              drain_done, rx_flush, tx_flush;
  logic [BYTE_W-1:0] rx_head;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic              rx_full, rx_empty, tx_full, tx_empty;
  logic              reg_mode;

  assign drain_done = run_q && !cfg_q[CFG_EN] && !eng_busy_i;
  assign rx_flush   = cfg_q[CFG_RXCLR] || drain_done;
  assign tx_flush   = cfg_q[CFG_TXCLR] && !cfg_q[CFG_EN];
  assign reg_mode   = !cfg_q[CFG_DMA];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= CFG_RESET;
      run_q     <= 1'b0;
      rx_done_q <= 1'b0;
      tx_done_q <= 1'b0;
      in_q      <= '0;
    end else begin
      if (cfg_wr_i) cfg_q <= cfg_wdata_i & CFG_MASK;
      if (cfg_q[CFG_EN])    run_q <= 1'b1;
      else if (!eng_busy_i) run_q <= 1'b0;
      rx_done_q <= rx_valid_i && run_q && !rx_full && !rx_flush;
      tx_done_q <= tx_flush;
      if (drain_done)   in_q <= '0;
      else if (in_rd_i) in_q <= (rx_empty || rx_flush) ? '0 : rx_head;
    end
  end

  i2c_rf_fifo #(.W(BYTE_W), .D(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_valid_i && run_q), .wdata(rx_data_i),
    .pop(in_rd_i), .rdata(rx_head), .count(rx_cnt),
    .full(rx_full), .empty(rx_empty)
  );

  i2c_rf_fifo #(.W(BYTE_W), .D(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(eg_wr_i), .wdata(eg_data_i),
    .pop(tx_take_i && run_q), .rdata(tx_data_o), .count(tx_cnt),
    .full(tx_full), .empty(tx_empty)
  );

  i2c_rf_sclgen #(.DIV(SCL_DIV)) u_scl (
    .clk(clk), .rst(rst), .run(run_q),
    .std_mode(cfg_q[CFG_STD]), .scl(scl_o)
  );

  always_comb begin
    status_o            = '0;
    status_o[ST_RXDONE] = rx_done_q;
    status_o[ST_RXDATA] = reg_mode && !rx_empty;
    status_o[ST_RXHALF] = reg_mode && (rx_cnt >= CW'(HALF));
    status_o[ST_TXDONE] = tx_done_q;
  end

  assign cfg_o      = cfg_q;
  assign in_data_o  = in_q;
  assign run_o      = run_q;
  assign tx_valid_o = run_q && !tx_empty;

  // R9
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cfg_q[CFG_EN] && eng_busy_i) |=> run_q);
  // R4
  rx_done_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done_q |-> $past(rx_valid_i));
  // R8
  tx_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[CFG_EN] && !tx_take_i && !tx_empty) |=> !tx_empty);
  // R12
  rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !in_rd_i) |=> $stable(rx_cnt) || rx_cnt == '0);

  logic unused_ok;
  assign unused_ok = ^{tx_full, tx_cnt};
endmodule

// File: tb/tb_i2c_regfront.sv
module tb_i2c_regfront;
  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_wr = 0, in_rd = 0, eg_wr = 0, tx_take = 0, rx_valid = 0, eng_busy = 0;
  logic [31:0] cfg_wdata = 0;
  logic [7:0]  eg_data = 0, rx_data = 0;
  logic [31:0] cfg, status;
  logic [7:0]  in_data, tx_data;
  logic        tx_valid, run, scl;
  int total = 0, bad = 0;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  always #4 clk = ~clk;

  i2c_regfront dut (
    .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_o(cfg),
    .status_o(status), .in_rd_i(in_rd), .in_data_o(in_data), .eg_wr_i(eg_wr),
    .eg_data_i(eg_data), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_take_i(tx_take),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .eng_busy_i(eng_busy), .run_o(run), .scl_o(scl)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(logic [31:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_rx(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    if (run && rxq.size() < 16) rxq.push_back(b);
    @(negedge clk); rx_valid = 0;
  endtask

  // ingress read, compared against scoreboard
  task automatic rd(string req);
    logic [7:0] e;
    e = (rxq.size() > 0) ? rxq.pop_front() : 8'h00;
    @(negedge clk); in_rd = 1;
    @(negedge clk); in_rd = 0;
    chk(req, {24'h0, in_data}, {24'h0, e});
  endtask

  task automatic push_tx(logic [7:0] b);
    @(negedge clk); eg_wr = 1; eg_data = b; txq.push_back(b);
    @(negedge clk); eg_wr = 0;
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    for (int i = 0; i < 100 && scl !== 1'b0; i++) @(negedge clk);
    for (int i = 0; i < 100 && scl !== 1'b1; i++) @(negedge clk);
    for (int i = 0; i < 100 && scl === 1'b1; i++) begin hi++; @(negedge clk); end
    for (int i = 0; i < 100 && scl === 1'b0; i++) begin lo++; @(negedge clk); end
  endtask

  // transmit monitor: compares each byte handed to the engine
  always begin
    @(negedge clk); #1;
    if (tx_valid && tx_take) begin
      chk("R10 tx order", {24'h0, tx_data},
          {24'h0, (txq.size() > 0) ? txq.pop_front() : 8'hxx});
    end
  end

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo;
    cyc(3); rst = 0; @(negedge clk);
    // R1 reset state
    chk("R1 cfg", cfg, 32'h4);
    chk("R1 status", status, 0);
    chk("R1 scl/run/txv", {29'h0, scl, run, tx_valid}, 32'h4);
    chk("R1 in_data", {24'h0, in_data}, 0);

    // R2 write/readback with masking
    wcfg(32'hFFFF_FFFF);
    chk("R2 mask", cfg, 32'hE000_0005);
    wcfg(32'h8000_0004);
    chk("R2 readback", cfg, 32'h8000_0004);
    cyc(1);
    chk("R9 run on", {31'h0, run}, 1);

    // R3 duty cycles
    measure(hi, lo);
    chk("R3 std high", hi, 10); chk("R3 std low", lo, 10);
    wcfg(32'h4); cyc(1);
    chk("R3 idle scl", {31'h0, scl}, 1);
    wcfg(32'h8000_0000); cyc(1);
    measure(hi, lo);
    chk("R3 fast high", hi, 8); chk("R3 fast low", lo, 12);
    wcfg(32'h4); cyc(1);
    // R12 rx ignored while stopped
    push_rx(8'hEE);
    chk("R12 ignored", status, 0);
    wcfg(32'h8000_0004); cyc(1);

    // R4/R5/R6 receive path
    @(negedge clk); rx_valid = 1; rx_data = 8'hA1; rxq.push_back(8'hA1);
    @(negedge clk); rx_valid = 0;
    chk("R4 done pulse", {31'h0, status[0]}, 1);
    @(negedge clk);
    chk("R4 done cleared", {31'h0, status[0]}, 0);
    push_rx(8'hA2); push_rx(8'hA3);
    chk("R5 data/half 3", {30'h0, status[2:1]}, 2'b01);
    rd("R6 first"); rd("R6 second"); rd("R6 third");
    chk("R5 empty after reads", {31'h0, status[1]}, 0);
    for (int i = 0; i < 8; i++) push_rx(8'h20 + 8'(i));
    chk("R5 half at 8", {30'h0, status[2:1]}, 2'b11);
    rd("R6 order");
    chk("R5 half after read", {30'h0, status[2:1]}, 2'b01);
    // R2 DMA mode masks flags
    wcfg(32'h8000_0005);
    chk("R2 dma mask", {30'h0, status[2:1]}, 0);
    wcfg(32'h8000_0004);
    for (int i = 0; i < 7; i++) rd("R6 drain");
    rd("R6 empty read");
    chk("R6 empty status", {31'h0, status[1]}, 0);

    // R11 overflow
    for (int i = 0; i < 18; i++) push_rx(8'h40 + 8'(i));
    chk("R11 full flags", {30'h0, status[2:1]}, 2'b11);
    for (int i = 0; i < 16; i++) rd("R11 contents");
    rd("R11 nothing extra");

    // R7 receive clear
    for (int i = 0; i < 4; i++) push_rx(8'h60 + 8'(i));
    wcfg(32'hA000_0004); cyc(1);
    rxq.delete();
    chk("R7 cleared", {31'h0, status[1]}, 0);
    wcfg(32'h8000_0004);
    rd("R7 read after clear");

    // R8 transmit clear while disabled
    wcfg(32'h4); cyc(1);
    push_tx(8'h71); push_tx(8'h72); push_tx(8'h73);
    chk("R10 no offer when stopped", {31'h0, tx_valid}, 0);
    wcfg(32'h4000_0004); cyc(1);
    txq.delete();
    chk("R8 tx done", {31'h0, status[3]}, 1);
    wcfg(32'h4); cyc(1);
    chk("R8 tx done drop", {31'h0, status[3]}, 0);
    wcfg(32'h8000_0004); cyc(1);
    chk("R8 tx emptied", {31'h0, tx_valid}, 0);
    wcfg(32'h4); cyc(1);
    push_tx(8'h81); push_tx(8'h82);
    wcfg(32'hC000_0004); cyc(2);
    chk("R8 clear ignored", {23'h0, tx_valid, tx_data}, {23'h0, 1'b1, 8'h81});
    chk("R8 no done while on", {31'h0, status[3]}, 0);
    @(negedge clk); tx_take = 1;
    cyc(2); tx_take = 0;
    @(negedge clk);
    chk("R10 drained", {31'h0, tx_valid}, 0);
    chk("R10 queue empty", txq.size(), 0);

    // R9 disable waits for byte end
    wcfg(32'h8000_0004); cyc(1);
    eng_busy = 1;
    push_rx(8'h91); push_rx(8'h92);
    rd("R9 read before off");
    wcfg(32'h4); cyc(3);
    chk("R9 run held", {31'h0, run}, 1);
    chk("R9 data kept", {31'h0, status[1]}, 1);
    eng_busy = 0;
    @(negedge clk);
    chk("R9 run low", {31'h0, run}, 0);
    chk("R9 rx flushed", {31'h0, status[1]}, 0);
    chk("R9 ingress cleared", {24'h0, in_data}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule